// File: doc/BRIEF.md
# Burst Header Receiver and Destination Steering

This block sits behind the electrical side of one ingress control channel of a slotted burst switch. Each control slot may deliver one 34-bit burst header frame on a parallel input qualified by a valid strobe. The block checks that the frame starts with the expected sync byte and that its parity byte matches the payload. Frames that fail either check are discarded, and a dedicated saturating counter records each kind of failure.

A frame that passes is repacked into a 24-bit reservation request. The sync byte, the parity byte and the destination field are removed, and the current value of an external 8-bit slot counter is attached as an arrival stamp. The request is then placed in a one-entry output register belonging to the destination port named in the frame. There are four such outputs, and each one has its own valid/ready handshake towards a destination queue.

A good frame whose destination register is still occupied, with its consumer not ready, is held at the input by dropping the input ready. It is never lost.

Top module: `bhp_rx_steer`

## Requirements
- R1: After a synchronous active-low reset, every `req_valid` bit is 0 and both error counters read 0.
- R2: Bits [33:26] of the frame must equal 8'hA5. On any other value, the frame is discarded and `sync_err_cnt` is one higher on the following cycle.
- R3: Bits [25:18] of the frame must equal the XOR of the three bytes of the 24-bit value {6'b0, frame[17:0]}. A frame with a good sync byte and a wrong parity byte is discarded and increments `par_err_cnt`. A frame with a bad sync byte never changes `par_err_cnt`.
- R4: The payload is laid out as frame[17:13] offset, [12:9] length, [8:5] ingress data channel, [4:3] ingress channel group, [2:1] destination and [0] QoS. The request is laid out as [23] QoS, [22:21] channel group, [20:17] data channel, [16:13] length, [12:8] offset and [7:0] timestamp.
- R5: The request timestamp equals `slot_cnt` in the cycle the frame is accepted.
- R6: An accepted good frame raises `req_valid[d]` on the next cycle, where d is the destination field. It raises no other output.
- R7: While `req_valid[d]` is high and `req_ready[d]` is low, the request on output d stays unchanged. A good frame for destination d is refused (`hdr_ready` low) until output d can take it, and it is delivered afterwards.
- R8: A frame that fails either check is always accepted (`hdr_ready` high), whatever the state of the outputs.
- R9: Each error counter stops at its all-ones value and does not wrap.
- R10: An occupied output whose consumer is ready in the same cycle accepts a new frame for it without a stall. Back-to-back frames to one destination pass at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | A frame is present on `hdr_frame` |
| hdr_ready | output | 1 | Frame is taken at this clock edge when `hdr_valid` is high |
| hdr_frame | input | 34 | Burst header frame, layout per R2 to R4 |
| slot_cnt | input | 8 | Running slot counter, used as the arrival stamp |
| req_valid | output | 4 | Per-destination request valid |
| req_ready | input | 4 | Per-destination consumer ready |
| req_data | output | 96 | Per-destination 24-bit request; destination d occupies bits [24d+23:24d] |
| sync_err_cnt | output | 8 | Saturating count of frames with a bad sync byte |
| par_err_cnt | output | 8 | Saturating count of frames with a good sync byte and bad parity |

## Verification
Two functions of this block can land on the same clock edge. In the first, an output hands its held request to its consumer while a new frame for that same destination is written into it. In the second, a bad frame is counted and dropped while a full output is stalled.

The bench provokes the first by streaming frames to one destination with its consumer always ready. Every frame must be taken without a stall, and the scoreboard must see each request exactly once, in order, with its own stamp. The second is provoked by filling an output with its consumer held off and then presenting a bad frame for that destination. The bad frame must be accepted at once and counted, while the held request stays unchanged.

// File: rtl/bhp_pkg.sv
// Package: shared frame and request layouts for the burst header receiver.
// Assumes a fixed 34-bit frame and a 24-bit request carrying an 8-bit stamp.
package bhp_pkg;

    localparam int FRAME_W   = 34;
    localparam int PAYLOAD_W = 18;
    localparam int TS_W      = 8;
    localparam int DEST_W    = 2;
    localparam int NUM_DEST  = 1 << DEST_W;
    localparam int REQ_W     = 1 + 2 + 4 + 4 + 5 + TS_W;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;

    // Incoming frame, most significant field first.
    typedef struct packed {
        logic [7:0]        sync;
        logic [7:0]        par;
        logic [4:0]        offset;
        logic [3:0]        len;
        logic [3:0]        chan;
        logic [1:0]        grp;
        logic [DEST_W-1:0] dest;
        logic              qos;
    } hdr_t;

    // Outgoing reservation request, most significant field first.
    typedef struct packed {
        logic            qos;
        logic [1:0]      grp;
        logic [3:0]      chan;
        logic [3:0]      len;
        logic [4:0]      offset;
        logic [TS_W-1:0] ts;
    } req_t;

    // Byte-wise XOR of the payload padded with zeros to three bytes.
    function automatic logic [7:0] payload_parity(input logic [PAYLOAD_W-1:0] p);
        logic [23:0] padded;
        padded = {{(24 - PAYLOAD_W){1'b0}}, p};
        return padded[23:16] ^ padded[15:8] ^ padded[7:0];
    endfunction

endpackage

// File: rtl/bhp_frame_check.sv
// Frame checker: validates the sync and parity bytes of one frame and
// builds the repacked request with the given stamp. Purely combinational.
module bhp_frame_check
    import bhp_pkg::*;
#(
    parameter logic [7:0] SYNC = SYNC_BYTE
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [TS_W-1:0]    stamp,
    output logic               sync_ok,
    output logic               par_ok,
    output logic [DEST_W-1:0]  dest,
    output logic [REQ_W-1:0]   req
);
    hdr_t h;
    req_t r;

    // Decode fields, run both checks and repack.
    always_comb begin
        h        = hdr_t'(frame);
        sync_ok  = (h.sync == SYNC);
        par_ok   = (h.par == payload_parity(frame[PAYLOAD_W-1:0]));
        dest     = h.dest;
        r.qos    = h.qos;
        r.grp    = h.grp;
        r.chan   = h.chan;
        r.len    = h.len;
        r.offset = h.offset;
        r.ts     = stamp;
        req      = REQ_W'(r);
    end
endmodule

// File: rtl/bhp_err_counter.sv
// Saturating event counter; holds at all-ones and never wraps.
module bhp_err_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count events until the counter is full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && (count != {W{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/bhp_dest_slot.sv
// One-entry output register for a single destination with valid/ready.
// It can be loaded when empty or when its content leaves in the same cycle.
module bhp_dest_slot #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         can_load,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // Space exists when empty or when draining this cycle.
    always_comb can_load = !out_valid || out_ready;

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (load)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Capture the request on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_data <= '0;
        else if (load)
            out_data <= load_data;
    end
endmodule

// File: rtl/bhp_rx_steer.sv
// Top: burst header receiver. It accepts one frame per cycle at most and
// validates it. Bad frames are dropped and counted. Good frames are repacked,
// stamped with slot_cnt and steered to a per-destination output register.
// Assumes slot_cnt is synchronous to clk.
module bhp_rx_steer
    import bhp_pkg::*;
#(
    parameter int         ERR_W = 8,
    parameter logic [7:0] SYNC  = SYNC_BYTE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hdr_valid,
    output logic                      hdr_ready,
    input  logic [FRAME_W-1:0]        hdr_frame,
    input  logic [TS_W-1:0]           slot_cnt,
    output logic [NUM_DEST-1:0]       req_valid,
    input  logic [NUM_DEST-1:0]       req_ready,
    output logic [NUM_DEST*REQ_W-1:0] req_data,
    output logic [ERR_W-1:0]          sync_err_cnt,
    output logic [ERR_W-1:0]          par_err_cnt
);
    logic              sync_ok;
    logic              par_ok;
    logic              good;
    logic              accept;
    logic [DEST_W-1:0] dest;
    logic [REQ_W-1:0]  req;
    logic [NUM_DEST-1:0] can_load;
    logic [NUM_DEST-1:0] load;

    bhp_frame_check #(.SYNC(SYNC)) check_i (
        .frame   (hdr_frame),
        .stamp   (slot_cnt),
        .sync_ok (sync_ok),
        .par_ok  (par_ok),
        .dest    (dest),
        .req     (req)
    );

    // Bad frames are always taken; good ones wait for room at their output.
    always_comb begin
        good      = sync_ok && par_ok;
        hdr_ready = !good || can_load[dest];
        accept    = hdr_valid && hdr_ready;
    end

    // One slot per destination, loaded only by a good frame addressed to it.
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
        always_comb load[d] = accept && good && (dest == DEST_W'(d));

        bhp_dest_slot #(.W(REQ_W)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[d]),
            .load_data (req),
            .can_load  (can_load[d]),
            .out_valid (req_valid[d]),
            .out_ready (req_ready[d]),
            .out_data  (req_data[d*REQ_W +: REQ_W])
        );
    end

    bhp_err_counter #(.W(ERR_W)) sync_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hdr_valid && !sync_ok),
        .count (sync_err_cnt)
    );

    bhp_err_counter #(.W(ERR_W)) par_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hdr_valid && sync_ok && !par_ok),
        .count (par_err_cnt)
    );
endmodule

// File: rtl/bhp_rx_steer_chk.sv
// Checker for bhp_rx_steer: relates the input handshake, the outputs and the
// counters over time. It is attached to every instance by the bind below.
module bhp_rx_steer_chk
    import bhp_pkg::*;
#(
    parameter int         ERR_W = 8,
    parameter logic [7:0] SYNC  = SYNC_BYTE
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      hdr_valid,
    input logic                      hdr_ready,
    input logic [FRAME_W-1:0]        hdr_frame,
    input logic [TS_W-1:0]           slot_cnt,
    input logic [NUM_DEST-1:0]       req_valid,
    input logic [NUM_DEST-1:0]       req_ready,
    input logic [NUM_DEST*REQ_W-1:0] req_data,
    input logic [ERR_W-1:0]          sync_err_cnt,
    input logic [ERR_W-1:0]          par_err_cnt
);
    logic in_sync_bad;
    logic in_par_bad;
    logic in_good_acc;

    // Independent view of the input classification.
    always_comb begin
        in_sync_bad = hdr_valid && (hdr_frame[33:26] != SYNC);
        in_par_bad  = hdr_valid && (hdr_frame[33:26] == SYNC) &&
                      (hdr_frame[25:18] != payload_parity(hdr_frame[17:0]));
        in_good_acc = hdr_valid && hdr_ready && !in_sync_bad && !in_par_bad;
    end

    assert_sync_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync_bad && (sync_err_cnt != {ERR_W{1'b1}})
        |=> sync_err_cnt == ERR_W'($past(sync_err_cnt) + 1'b1));

    assert_par_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_par_bad && (par_err_cnt != {ERR_W{1'b1}})
        |=> par_err_cnt == ERR_W'($past(par_err_cnt) + 1'b1));

    assert_sync_precedes_par_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync_bad |=> $stable(par_err_cnt));

    assert_bad_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync_bad || in_par_bad) |-> hdr_ready);

    assert_sync_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_cnt == {ERR_W{1'b1}}) |=> (sync_err_cnt == {ERR_W{1'b1}}));

    assert_par_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_cnt == {ERR_W{1'b1}}) |=> (par_err_cnt == {ERR_W{1'b1}}));

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_d
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[d] && !req_ready[d]
            |=> req_valid[d] && $stable(req_data[d*REQ_W +: REQ_W]));

        assert_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
            in_good_acc && (hdr_frame[2:1] == DEST_W'(d)) |=> req_valid[d]);

        assert_stamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_good_acc && (hdr_frame[2:1] == DEST_W'(d))
            |=> req_data[d*REQ_W +: TS_W] == $past(slot_cnt));

        assert_no_stray_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[d] && !(in_good_acc && (hdr_frame[2:1] == DEST_W'(d)))
            |=> !req_valid[d]);
    end
endmodule

bind bhp_rx_steer bhp_rx_steer_chk #(.ERR_W(ERR_W), .SYNC(SYNC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_valid    (hdr_valid),
    .hdr_ready    (hdr_ready),
    .hdr_frame    (hdr_frame),
    .slot_cnt     (slot_cnt),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_data     (req_data),
    .sync_err_cnt (sync_err_cnt),
    .par_err_cnt  (par_err_cnt)
);

// File: tb/bhp_rx_steer_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected requests per destination,
// and the monitor pops and compares them as outputs hand over.
module bhp_rx_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [33:0] hdr_frame = '0;
    logic [7:0]  slot_cnt = 8'h37;
    logic [3:0]  req_valid;
    logic [3:0]  req_ready = 4'hF;
    logic [95:0] req_data;
    logic [7:0]  sync_err_cnt;
    logic [7:0]  par_err_cnt;

    int checks = 0;
    int fails = 0;
    int exp_sync = 0;
    int exp_par = 0;
    int stall_cycles = 0;
    int ready_mode = 0;
    logic [23:0] expq [4][$];
    logic [3:0]  prev_stall = '0;
    logic [23:0] prev_data [4];

    always #2.5 clk = ~clk;

    bhp_rx_steer dut_i (
        .clk (clk), .rst_n (rst_n), .hdr_valid (hdr_valid), .hdr_ready (hdr_ready),
        .hdr_frame (hdr_frame), .slot_cnt (slot_cnt), .req_valid (req_valid),
        .req_ready (req_ready), .req_data (req_data),
        .sync_err_cnt (sync_err_cnt), .par_err_cnt (par_err_cnt)
    );

    task automatic check_val(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [33:0] mk(input logic [7:0] s, input logic [4:0] off,
        input logic [3:0] len, input logic [3:0] ch, input logic [1:0] grp,
        input logic [1:0] dst, input logic q, input logic [7:0] flip);
        logic [17:0] p;
        logic [23:0] pad;
        p   = {off, len, ch, grp, dst, q};
        pad = {6'b0, p};
        return {s, (pad[23:16] ^ pad[15:8] ^ pad[7:0]) ^ flip, p};
    endfunction

    // Slot counter stepping by 3 each cycle.
    always @(negedge clk) slot_cnt <= slot_cnt + 8'd3;

    // Consumer ready patterns.
    always @(negedge clk) begin
        case (ready_mode)
            0: req_ready <= 4'hF;
            1: req_ready <= 4'h0;
            default: req_ready <= 4'($urandom);
        endcase
    end

    // Monitor: compare handed-over requests and check held outputs (R4 R5 R6 R7).
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            for (int d = 0; d < 4; d++) begin
                if (prev_stall[d]) begin
                    check_val("R7 held valid", 32'(req_valid[d]), 32'd1);
                    check_val("R7 held data", 32'(req_data[d*24 +: 24]), 32'(prev_data[d]));
                end
                if (req_valid[d] && req_ready[d]) begin
                    if (expq[d].size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R6: actual unexpected request %0h on output %0d expected none",
                                 req_data[d*24 +: 24], d);
                    end else begin
                        check_val("R4 R5 R6 request", 32'(req_data[d*24 +: 24]),
                                  32'(expq[d].pop_front()));
                    end
                end
                prev_stall[d] = req_valid[d] && !req_ready[d];
                prev_data[d]  = req_data[d*24 +: 24];
            end
        end
    end

    // Present one frame, hold it until taken and record what is expected.
    task automatic send(input logic [33:0] f);
        bit good;
        good = (f[33:26] == 8'hA5) &&
               (f[25:18] == ({6'b0, f[17:16]} ^ f[15:8] ^ f[7:0]));
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_frame = f;
        #1;
        check_val("R2 sync count", 32'(sync_err_cnt), 32'(exp_sync));
        check_val("R3 parity count", 32'(par_err_cnt), 32'(exp_par));
        if (!good) check_val("R8 bad frame taken", 32'(hdr_ready), 32'd1);
        while (!hdr_ready) begin
            stall_cycles++;
            @(negedge clk);
            #1;
        end
        if (good)
            expq[f[2:1]].push_back({f[0], f[4:3], f[8:5], f[12:9], f[17:13], slot_cnt});
        else if (f[33:26] != 8'hA5)
            exp_sync = (exp_sync == 255) ? 255 : exp_sync + 1;
        else
            exp_par = (exp_par == 255) ? 255 : exp_par + 1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            hdr_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check_val("R1 valid after reset", 32'(req_valid), 32'd0);
        check_val("R1 sync count after reset", 32'(sync_err_cnt), 32'd0);
        check_val("R1 parity count after reset", 32'(par_err_cnt), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R5 R6: one frame to each destination, distinct field values.
        for (int d = 0; d < 4; d++)
            send(mk(8'hA5, 5'(7 * d + 3), 4'(d + 9), 4'(15 - d), 2'(d), 2'(d), d[0], 8'h00));
        idle(3);

        // R2 R3: bad sync, bad parity, and both bad (only sync counts).
        send(mk(8'h5A, 5'd1, 4'd2, 4'd3, 2'd1, 2'd2, 1'b1, 8'h00));
        send(mk(8'hA5, 5'd4, 4'd5, 4'd6, 2'd2, 2'd1, 1'b0, 8'h10));
        send(mk(8'hA4, 5'd9, 4'd1, 4'd0, 2'd3, 2'd3, 1'b1, 8'h01));
        send(mk(8'hA5, 5'd31, 4'd15, 4'd15, 2'd3, 2'd3, 1'b1, 8'h00));
        idle(2);

        // R10: back-to-back to one destination with its consumer ready.
        stall_cycles = 0;
        for (int i = 0; i < 6; i++)
            send(mk(8'hA5, 5'(i), 4'(i + 1), 4'(i + 2), 2'(i), 2'd2, i[0], 8'h00));
        check_val("R10 no stall back-to-back", 32'(stall_cycles), 32'd0);
        idle(3);

        // R7 R8: fill output 1 with its consumer off, then stall a second frame.
        ready_mode = 1;
        idle(2);
        send(mk(8'hA5, 5'd11, 4'd7, 4'd8, 2'd1, 2'd1, 1'b0, 8'h00));
        send(mk(8'h00, 5'd0, 4'd0, 4'd0, 2'd0, 2'd1, 1'b0, 8'h00));
        send(mk(8'hA5, 5'd0, 4'd0, 4'd0, 2'd0, 2'd1, 1'b0, 8'h80));
        stall_cycles = 0;
        fork
            send(mk(8'hA5, 5'd22, 4'd3, 4'd12, 2'd2, 2'd1, 1'b1, 8'h00));
            begin
                repeat (6) @(negedge clk);
                #2;
                check_val("R7 frame refused while full", 32'(stall_cycles >= 4), 32'd1);
                ready_mode = 0;
            end
        join
        idle(4);

        // Mixed traffic with random consumer readiness.
        ready_mode = 2;
        for (int i = 0; i < 80; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 7 == 3)
                send(mk(8'hA5, r[4:0], r[8:5], r[12:9], r[14:13], r[16:15], r[17], 8'h04));
            else
                send(mk(8'hA5, r[4:0], r[8:5], r[12:9], r[14:13], r[16:15], r[17], 8'h00));
        end
        ready_mode = 0;
        idle(4);

        // R9: drive the sync counter past its limit.
        for (int i = 0; i < 260; i++)
            send(mk(8'(i), 5'd0, 4'd0, 4'd0, 2'd0, 2'd0, 1'b0, (i == 165) ? 8'h00 : 8'h00));
        idle(2);
        #1;
        check_val("R9 sync count saturates", 32'(sync_err_cnt), 32'd255);
        check_val("R3 parity count final", 32'(par_err_cnt), 32'(exp_par));

        idle(4);
        for (int d = 0; d < 4; d++)
            check_val("R6 all expected requests delivered", 32'(expq[d].size()), 32'd0);
        check_val("R6 outputs idle at end", 32'(req_valid), 32'd0);
        summary();
        $finish;
    end
endmodule